// File: doc/BRIEF.md
# Indexed Interrupt Pin Router

The block gathers up to 24 interrupt input pins and turns them into interrupt messages for a processor-side controller. Software reaches every internal register through two bus locations. A select register at bus offset 0x00 holds an index. A data window at bus offset 0x10 reads or writes the register that the index names. The index space holds an identification word, a version word, an arbitration word and one two-word routing entry for each pin.

Each routing entry tells the block how to sample its pin: which polarity is active, whether the pin is edge- or level-sensitive, and whether it is masked. The entry also gives the contents of the outgoing message: vector, delivery mode, destination mode and destination. A message is offered on a valid/ready pair and is held until it is accepted. Level-sensitive pins then wait for an end-of-interrupt carrying their vector before they can be delivered again.

Top module: `irq_router`

## Requirements
- R1: After reset every entry low word reads 0x0001_0000 (masked, edge, active high, vector 0). Every high word reads 0. The select register reads 0 and no message is offered. The version word (index 1) reads the number of the highest entry (23) in bits 23:16 and the VERSION parameter (default 0x11) in bits 7:0.
- R2: A write at offset 0x00 loads the select register (bits 7:0), and the window at offset 0x10 then reads and writes the selected register. Entry n is at index 0x10+2n (low word) and 0x10+2n+1 (high word). The destination is bits 31:24 of the high word. Any other bus offset reads zero.
- R3: Low-word fields: vector 7:0, delivery mode 10:8, logical destination 11, delivery status 12, active-low polarity 13, remote-IRR 14, level trigger 15, mask 16. Bits 23:17 and 31:24 of the low word, and bits 23:0 of the high word, read zero.
- R4: Writes to bit 12 and bit 14 of a low word have no effect on what reads back.
- R5: Index 0 holds a 4-bit ID in bits 27:24 and index 2 reads the same ID there. Indexes that map to no register read zero, and writes to them change nothing.
- R6: An edge pin raises one message for each inactive-to-active change of its input after polarity is applied. A pin that stays active raises no further message.
- R7: A level pin raises a message while it is active and its remote-IRR is clear. Acceptance sets remote-IRR. Only an end-of-interrupt carrying the entry's vector clears it, and redelivery follows if the pin is still active.
- R8: A set mask bit stops a pin from raising messages. An edge that arrives while the pin is masked is dropped.
- R9: The offered message carries the entry's vector, delivery mode, destination mode and destination, and it stays unchanged until accepted. Delivery status reads 1 from the cycle the message is raised until the acceptance.
- R10: When several pins request at the same time, the lowest-numbered pin is delivered first. The next pin follows after the current message is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 5 | Bus offset: 0x00 select, 0x10 window |
| wr_i | input | 1 | Bus write strobe |
| wdata_i | input | 32 | Bus write data |
| rdata_o | output | 32 | Bus read data (combinational) |
| pin_i | input | 24 | Interrupt input pins |
| msg_valid_o | output | 1 | Message offered |
| msg_ready_i | input | 1 | Message taken this cycle |
| msg_vector_o | output | 8 | Message vector |
| msg_dmode_o | output | 3 | Message delivery mode |
| msg_dst_logical_o | output | 1 | Message destination mode, 1 logical |
| msg_dest_o | output | 8 | Message destination |
| eoi_valid_i | input | 1 | End-of-interrupt strobe |
| eoi_vector_i | input | 8 | End-of-interrupt vector |

## Verification
Window reads are combinational, so the bench samples them in the same cycle once the select register is loaded. A pin change driven between edges is registered at the first rising edge and turns into an offered message at the second, and the bench samples just after that second edge. An acceptance removes the message at the edge where it is seen, and a waiting pin is offered at the following edge. A matching end-of-interrupt clears remote-IRR at one edge, and a still-active level pin is offered at the next. Each check is placed at the falling edge that follows the edge on which the result is due.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  typedef struct packed {
    logic [7:0] dest;
    logic       mask;
    logic       trig_lvl;
    logic       pol_low;
    logic       dst_logical;
    logic [2:0] dmode;
    logic [7:0] vector;
  } route_cfg_t;

  typedef struct packed {
    logic [7:0] dest;
    logic       dst_logical;
    logic [2:0] dmode;
    logic [7:0] vector;
  } route_msg_t;

  localparam route_cfg_t CFG_RESET = '{mask: 1'b1, default: '0};

  localparam logic [4:0] OFS_SEL = 5'h00;
  localparam logic [4:0] OFS_WIN = 5'h10;
  localparam logic [7:0] IDX_ID  = 8'h00;
  localparam logic [7:0] IDX_VER = 8'h01;
  localparam logic [7:0] IDX_ARB = 8'h02;
  localparam logic [7:0] IDX_TBL = 8'h10;
endpackage

// File: rtl/irq_router_regs.sv
module irq_router_regs
  import irq_router_pkg::*;
#(
  parameter int unsigned NUM_PINS = 24,
  parameter logic [7:0]  VERSION  = 8'h11
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [4:0]                        addr_i,
  input  logic                              wr_i,
  input  logic [31:0]                       wdata_i,
  output logic [31:0]                       rdata_o,
  input  logic [NUM_PINS-1:0]               ds_i,
  input  logic [NUM_PINS-1:0]               rirr_i,
  output route_cfg_t [NUM_PINS-1:0]         cfg_o
);
  localparam logic [7:0] TBL_END = 8'(32'(IDX_TBL) + 2 * NUM_PINS);
  localparam logic [7:0] TOP_ENT = 8'(NUM_PINS - 1);

  logic [7:0]  idx_q;
  logic [3:0]  id_q;
  route_cfg_t  cfg_q [NUM_PINS];
  logic [7:0]  tbl_off;
  logic [6:0]  ent;
  logic        in_tbl, win_wr;
  route_cfg_t  sel_cfg;
  logic        sel_ds, sel_rirr;
  logic [31:0] win_rd;
  logic        unused_bits;

  assign unused_bits = ^{wdata_i[23:17], wdata_i[14], wdata_i[12]};
  assign tbl_off = idx_q - IDX_TBL;
  assign ent     = tbl_off[7:1];
  assign in_tbl  = (idx_q >= IDX_TBL) && (idx_q < TBL_END);
  assign win_wr  = wr_i && (addr_i == OFS_WIN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      id_q  <= '0;
    end else begin
      if (wr_i && addr_i == OFS_SEL) idx_q <= wdata_i[7:0];
      if (win_wr && idx_q == IDX_ID) id_q <= wdata_i[27:24];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int n = 0; n < NUM_PINS; n++) cfg_q[n] <= CFG_RESET;
    end else if (win_wr && in_tbl) begin
      for (int n = 0; n < NUM_PINS; n++) begin
        if (ent == 7'(n)) begin
          if (idx_q[0]) begin
            cfg_q[n].dest <= wdata_i[31:24];
          end else begin
            cfg_q[n].vector      <= wdata_i[7:0];
            cfg_q[n].dmode       <= wdata_i[10:8];
            cfg_q[n].dst_logical <= wdata_i[11];
            cfg_q[n].pol_low     <= wdata_i[13];
            cfg_q[n].trig_lvl    <= wdata_i[15];
            cfg_q[n].mask        <= wdata_i[16];
          end
        end
      end
    end
  end

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_cfg
    assign cfg_o[n] = cfg_q[n];
  end

  always_comb begin
    sel_cfg  = '0;
    sel_ds   = 1'b0;
    sel_rirr = 1'b0;
    for (int n = 0; n < NUM_PINS; n++) begin
      if (ent == 7'(n)) begin
        sel_cfg  = cfg_q[n];
        sel_ds   = ds_i[n];
        sel_rirr = rirr_i[n];
      end
    end
    win_rd = '0;
    if (idx_q == IDX_ID || idx_q == IDX_ARB) begin
      win_rd = {4'b0, id_q, 24'b0};
    end else if (idx_q == IDX_VER) begin
      win_rd = {8'b0, TOP_ENT, 8'b0, VERSION};
    end else if (in_tbl) begin
      if (idx_q[0]) win_rd = {sel_cfg.dest, 24'b0};
      else          win_rd = {15'b0, sel_cfg.mask, sel_cfg.trig_lvl, sel_rirr,
                              sel_cfg.pol_low, sel_ds, sel_cfg.dst_logical,
                              sel_cfg.dmode, sel_cfg.vector};
    end
  end

  always_comb begin
    if (addr_i == OFS_SEL)      rdata_o = {24'b0, idx_q};
    else if (addr_i == OFS_WIN) rdata_o = win_rd;
    else                        rdata_o = '0;
  end
endmodule

// File: rtl/irq_router_pin.sv
module irq_router_pin (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pin_i,
  input  logic       pol_low_i,
  input  logic       trig_lvl_i,
  input  logic       mask_i,
  input  logic [7:0] vector_i,
  input  logic       launch_i,
  input  logic       accept_i,
  input  logic       eoi_valid_i,
  input  logic [7:0] eoi_vector_i,
  output logic       req_o,
  output logic       ds_o,
  output logic       rirr_o
);
  logic act, rise, eoi_hit;
  logic samp_q, edge_pend_q, rirr_q, ds_q;

  assign act     = pin_i ^ pol_low_i;
  assign rise    = act & ~samp_q;
  assign eoi_hit = eoi_valid_i && (eoi_vector_i == vector_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      samp_q      <= 1'b0;
      edge_pend_q <= 1'b0;
      rirr_q      <= 1'b0;
      ds_q        <= 1'b0;
    end else begin
      samp_q <= act;
      // an edge seen while masked is dropped
      edge_pend_q <= trig_lvl_i ? 1'b0 : ((edge_pend_q & ~accept_i) | (rise & ~mask_i));
      if (!trig_lvl_i)   rirr_q <= 1'b0;
      else if (accept_i) rirr_q <= 1'b1;
      else if (eoi_hit)  rirr_q <= 1'b0;
      if (launch_i)      ds_q <= 1'b1;
      else if (accept_i) ds_q <= 1'b0;
    end
  end

  assign req_o  = ~mask_i & ~ds_q & (trig_lvl_i ? (samp_q & ~rirr_q) : edge_pend_q);
  assign ds_o   = ds_q;
  assign rirr_o = rirr_q;

  assert_mask_blocks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_i |-> !mask_i);
  assert_rirr_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rirr_q) |-> $past(accept_i && trig_lvl_i));
  assert_rirr_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rirr_q && trig_lvl_i && !eoi_hit) |=> rirr_q);
  assert_ds_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ds_q && !accept_i) |=> ds_q);
endmodule

// File: rtl/irq_router_arb.sv
module irq_router_arb
  import irq_router_pkg::*;
#(
  parameter int unsigned NUM_PINS = 24
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_PINS-1:0]       req_i,
  input  route_msg_t [NUM_PINS-1:0] cand_i,
  input  logic                      msg_ready_i,
  output logic [NUM_PINS-1:0]       launch_o,
  output logic [NUM_PINS-1:0]       accept_o,
  output logic                      msg_valid_o,
  output route_msg_t                msg_o
);
  localparam int unsigned IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

  logic [IDX_W-1:0] pick, src_q;
  logic             hit, valid_q;
  route_msg_t       msg_q;

  always_comb begin
    pick = '0;
    hit  = 1'b0;
    for (int i = NUM_PINS - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        pick = IDX_W'(i);
        hit  = 1'b1;
      end
    end
    launch_o = '0;
    accept_o = '0;
    if (hit && !valid_q)        launch_o[pick]  = 1'b1;
    if (valid_q && msg_ready_i) accept_o[src_q] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      src_q   <= '0;
      msg_q   <= '0;
    end else if (!valid_q) begin
      if (hit) begin
        valid_q <= 1'b1;
        src_q   <= pick;
        msg_q   <= cand_i[pick];
      end
    end else if (msg_ready_i) begin
      valid_q <= 1'b0;
    end
  end

  assign msg_valid_o = valid_q;
  assign msg_o       = msg_q;

  assert_msg_stable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && !msg_ready_i) |=> (valid_q && $stable(msg_q)));
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int unsigned NUM_PINS = 24,
  parameter logic [7:0]  VERSION  = 8'h11
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [4:0]          addr_i,
  input  logic                wr_i,
  input  logic [31:0]         wdata_i,
  output logic [31:0]         rdata_o,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic                msg_valid_o,
  input  logic                msg_ready_i,
  output logic [7:0]          msg_vector_o,
  output logic [2:0]          msg_dmode_o,
  output logic                msg_dst_logical_o,
  output logic [7:0]          msg_dest_o,
  input  logic                eoi_valid_i,
  input  logic [7:0]          eoi_vector_i
);
  route_cfg_t [NUM_PINS-1:0] cfg;
  route_msg_t [NUM_PINS-1:0] cand;
  route_msg_t                msg;
  logic [NUM_PINS-1:0]       ds, rirr, req, launch, accept;

  irq_router_regs #(.NUM_PINS(NUM_PINS), .VERSION(VERSION)) u_regs (
    .clk_i, .rst_ni, .addr_i, .wr_i, .wdata_i, .rdata_o,
    .ds_i(ds), .rirr_i(rirr), .cfg_o(cfg)
  );

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
    assign cand[n] = '{dest: cfg[n].dest, dst_logical: cfg[n].dst_logical,
                       dmode: cfg[n].dmode, vector: cfg[n].vector};
    irq_router_pin u_pin (
      .clk_i, .rst_ni,
      .pin_i(pin_i[n]), .pol_low_i(cfg[n].pol_low), .trig_lvl_i(cfg[n].trig_lvl),
      .mask_i(cfg[n].mask), .vector_i(cfg[n].vector),
      .launch_i(launch[n]), .accept_i(accept[n]),
      .eoi_valid_i, .eoi_vector_i,
      .req_o(req[n]), .ds_o(ds[n]), .rirr_o(rirr[n])
    );
  end

  irq_router_arb #(.NUM_PINS(NUM_PINS)) u_arb (
    .clk_i, .rst_ni, .req_i(req), .cand_i(cand), .msg_ready_i,
    .launch_o(launch), .accept_o(accept), .msg_valid_o, .msg_o(msg)
  );

  assign msg_vector_o      = msg.vector;
  assign msg_dmode_o       = msg.dmode;
  assign msg_dst_logical_o = msg.dst_logical;
  assign msg_dest_o        = msg.dest;

  assert_ds_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ds));
  assert_ds_tracks_msg_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o == (|ds));
endmodule

// File: tb/sim_irq_router.sv
module sim_irq_router;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  addr = '0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [23:0] pins = '0;
  logic        msg_valid, msg_ready = 1'b0;
  logic [7:0]  msg_vector, msg_dest;
  logic [2:0]  msg_dmode;
  logic        msg_dstl;
  logic        eoi_valid = 1'b0;
  logic [7:0]  eoi_vector = '0;
  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  irq_router u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .wdata_i(wdata),
    .rdata_o(rdata), .pin_i(pins), .msg_valid_o(msg_valid), .msg_ready_i(msg_ready),
    .msg_vector_o(msg_vector), .msg_dmode_o(msg_dmode), .msg_dst_logical_o(msg_dstl),
    .msg_dest_o(msg_dest), .eoi_valid_i(eoi_valid), .eoi_vector_i(eoi_vector)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mword(input logic v, input logic [7:0] dest,
                                        input logic dstl, input logic [2:0] dm,
                                        input logic [7:0] vec);
    return {7'b0, v, dest, 4'b0, dstl, dm, vec};
  endfunction

  function automatic logic [31:0] cur_msg();
    return {7'b0, msg_valid, msg_dest, 4'b0, msg_dstl, msg_dmode, msg_vector};
  endfunction

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_bus(input logic [4:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic wr_reg(input logic [7:0] idx, input logic [31:0] d);
    wr_bus(5'h00, {24'b0, idx});
    wr_bus(5'h10, d);
  endtask

  task automatic rd_reg(input logic [7:0] idx, output logic [31:0] d);
    wr_bus(5'h00, {24'b0, idx});
    addr = 5'h10;
    #1 d = rdata;
  endtask

  task automatic accept();
    msg_ready = 1'b1;
    step(1);
    msg_ready = 1'b0;
  endtask

  task automatic send_eoi(input logic [7:0] v);
    eoi_vector = v; eoi_valid = 1'b1;
    step(1);
    eoi_valid = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    addr = 5'h00;
    #1 chk("R1", "select after reset", rdata, 32'h0);
    chk("R1", "no message", {31'b0, msg_valid}, 32'h0);
    rd_reg(8'h10, d); chk("R1", "entry0 low", d, 32'h0001_0000);
    rd_reg(8'h3E, d); chk("R1", "entry23 low", d, 32'h0001_0000);
    rd_reg(8'h3F, d); chk("R1", "entry23 high", d, 32'h0);
    rd_reg(8'h01, d); chk("R1", "version word", d, 32'h0017_0011);
  endtask

  task automatic t_access();
    logic [31:0] d;
    wr_reg(8'h3F, 32'hC3FF_FFFF);
    rd_reg(8'h3F, d); chk("R2", "entry23 dest", d, 32'hC300_0000);
    rd_reg(8'h3D, d); chk("R2", "entry22 high untouched", d, 32'h0);
    addr = 5'h04;
    #1 chk("R2", "other offset", rdata, 32'h0);
    wr_reg(8'h10, 32'hFFFF_FFFF);
    rd_reg(8'h10, d); chk("R3", "low field layout", d, 32'h0001_AFFF);
    chk("R4", "status bits ignore writes", d & 32'h0000_5000, 32'h0);
    wr_reg(8'h10, 32'h0001_0000);
    rd_reg(8'h10, d); chk("R3", "entry0 restored", d, 32'h0001_0000);
  endtask

  task automatic t_id_unmapped();
    logic [31:0] d;
    wr_reg(8'h00, 32'hFFFF_FFFF);
    rd_reg(8'h00, d); chk("R5", "id word", d, 32'h0F00_0000);
    rd_reg(8'h02, d); chk("R5", "arb word", d, 32'h0F00_0000);
    wr_reg(8'h40, 32'hFFFF_FFFF);
    rd_reg(8'h40, d); chk("R5", "past table", d, 32'h0);
    wr_reg(8'h03, 32'hFFFF_FFFF);
    rd_reg(8'h03, d); chk("R5", "hole index 3", d, 32'h0);
    rd_reg(8'h3E, d); chk("R5", "entry23 low unchanged", d, 32'h0001_0000);
  endtask

  task automatic t_edge();
    logic [31:0] d;
    wr_reg(8'h17, 32'h5A00_0000);
    wr_reg(8'h16, 32'h0000_0433);
    pins[3] = 1'b1;
    step(2);
    chk("R6", "edge message", cur_msg(), mword(1, 8'h5A, 0, 3'd4, 8'h33));
    rd_reg(8'h16, d); chk("R9", "status while pending", d, 32'h0000_1433);
    chk("R9", "message held", cur_msg(), mword(1, 8'h5A, 0, 3'd4, 8'h33));
    accept();
    chk("R9", "cleared at accept", {31'b0, msg_valid}, 32'h0);
    rd_reg(8'h16, d); chk("R9", "status after accept", d, 32'h0000_0433);
    step(4);
    chk("R6", "steady level no repeat", {31'b0, msg_valid}, 32'h0);
    pins[3] = 1'b0; step(1);
    pins[3] = 1'b1; step(2);
    chk("R6", "second edge", cur_msg(), mword(1, 8'h5A, 0, 3'd4, 8'h33));
    accept();
    pins[3] = 1'b0;
  endtask

  task automatic t_active_low();
    wr_reg(8'h18, 32'h0001_2044);
    wr_reg(8'h18, 32'h0000_2044);
    step(2);
    chk("R8", "edge while masked dropped", {31'b0, msg_valid}, 32'h0);
    pins[4] = 1'b1; step(1);
    pins[4] = 1'b0; step(2);
    chk("R6", "active-low edge", cur_msg(), mword(1, 8'h00, 0, 3'd0, 8'h44));
    accept();
  endtask

  task automatic t_mask();
    wr_reg(8'h1C, 32'h0001_0066);
    pins[6] = 1'b1; step(1);
    pins[6] = 1'b0; step(2);
    chk("R8", "masked edge pin", {31'b0, msg_valid}, 32'h0);
    wr_reg(8'h1C, 32'h0000_0066);
    step(2);
    chk("R8", "masked edge not replayed", {31'b0, msg_valid}, 32'h0);
    wr_reg(8'h1E, 32'h0001_8077);
    pins[7] = 1'b1; step(3);
    chk("R8", "masked level pin", {31'b0, msg_valid}, 32'h0);
    wr_reg(8'h1E, 32'h0000_8077);
    step(1);
    chk("R8", "level after unmask", cur_msg(), mword(1, 8'h00, 0, 3'd0, 8'h77));
    pins[7] = 1'b0;
    accept();
    send_eoi(8'h77);
  endtask

  task automatic t_level();
    logic [31:0] d;
    wr_reg(8'h1B, 32'h7E00_0000);
    wr_reg(8'h1A, 32'h0000_8955);
    pins[5] = 1'b1;
    step(2);
    chk("R7", "level message", cur_msg(), mword(1, 8'h7E, 1, 3'd1, 8'h55));
    wr_reg(8'h1A, 32'h0000_8955);
    rd_reg(8'h1A, d); chk("R4", "write keeps status", d, 32'h0000_9955);
    accept();
    rd_reg(8'h1A, d); chk("R7", "remote flag set", d, 32'h0000_C955);
    step(3);
    chk("R7", "no redelivery while flagged", {31'b0, msg_valid}, 32'h0);
    send_eoi(8'h56);
    rd_reg(8'h1A, d); chk("R7", "other vector ignored", d, 32'h0000_C955);
    chk("R7", "still quiet", {31'b0, msg_valid}, 32'h0);
    send_eoi(8'h55);
    step(1);
    chk("R7", "redelivery after eoi", cur_msg(), mword(1, 8'h7E, 1, 3'd1, 8'h55));
    pins[5] = 1'b0;
    accept();
    send_eoi(8'h55);
    step(2);
    chk("R7", "inactive after eoi", {31'b0, msg_valid}, 32'h0);
  endtask

  task automatic t_priority();
    wr_reg(8'h12, 32'h0000_0011);
    wr_reg(8'h14, 32'h0000_0022);
    pins[2] = 1'b1; pins[1] = 1'b1;
    step(2);
    chk("R10", "lowest pin first", cur_msg(), mword(1, 8'h00, 0, 3'd0, 8'h11));
    accept();
    chk("R10", "gap after accept", {31'b0, msg_valid}, 32'h0);
    step(1);
    chk("R10", "next pin follows", cur_msg(), mword(1, 8'h00, 0, 3'd0, 8'h22));
    accept();
    pins[2] = 1'b0; pins[1] = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_access();
    t_id_unmapped();
    t_edge();
    t_active_low();
    t_mask();
    t_level();
    t_priority();
    finish_run();
  end
endmodule